// File: doc/BRIEF.md
# Offset-Preset BCD Frequency Counter

This block measures a receiver's operating frequency from its local-oscillator pulses without any subtractor. A five-digit BCD count register, with 10 Hz per count, is loaded with an offset at the start of each gate and then counts the selected pulse source up or down. The offset-adjusted result therefore comes out modulo 100000 counts. The offset is either a fixed constant or a measured one. The fixed constant is formed from four orthogonal sideband and scheme lines. The measured offset comes from a second register that counts the carrier oscillator during the same gate in which the VFO is counted. It counts in the opposite direction to the count register, and its result becomes the preset for the next gate, so the refresh rate is not halved.

At every gate end the count is copied into the display latches and the count register is reloaded. For a set number of clock cycles after reset, a power-on cycling phase runs instead. In that phase the count register counts a 10 kHz tick upward and the display follows the count directly, so that every digit value is shown. Wraps out of the leading digit are reported as one-cycle carry and borrow pulses for a MHz stage that sits outside this block.

Top module: `offset_preset_counter`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `disp_bcd`, `khz_carry` and `khz_borrow` are all zero.
- R2: For TUBE_CYCLES clock cycles after reset, the count register counts `tick_pulse` upward from zero and ignores `gate_end`. `disp_bcd` shows the count as it runs. After this phase the count register is loaded with the preset, `disp_bcd` shows the latched value (zero until the first gate end), and the phase never returns until the next reset.
- R3: When `ofs_count_en`=0, the preset in tens-of-Hz units is as follows: 10000 for `sel_cent`; 90000 for `sel_cent`+`sel_nm2`; 09820 for `sel_usb`; 89820 for `sel_usb`+`sel_nm2`; 10180 for `sel_lsb`; 90180 for `sel_lsb`+`sel_nm2`; 0 with all four lines low.
- R4: With `dir_down`=1, each selected pulse decrements the count. The readout is (preset − pulses) mod 100000.
- R5: With `dir_down`=0, each selected pulse increments the count. The readout is (preset + pulses) mod 100000.
- R6: `src_sel` picks the counted source as follows: 0 selects `vfo_pulse`, 1 selects `ext_pulse`, 2 selects `car_pulse` and 3 selects `tick_pulse`. Pulses on unselected sources have no effect on the readout.
- R7: When `ofs_count_en`=1, the offset register starts each gate at zero and counts `car_pulse` in the direction opposite to `dir_down`. Its final value presets the next gate. With `dir_down`=1 the next readout is C−V, and with `dir_down`=0 it is V−C (mod 100000).
- R8: When `ofs_count_en`=0, carrier pulses do not enter the preset. The offset register is loaded with the fixed constant every cycle.
- R9: After the power-on phase, `disp_bcd` changes only in the cycle after a `gate_end` strobe.
- R10: A pulse that arrives in the same cycle as `gate_end` is counted in the closing gate, both in the count register and in the offset register.
- R11: When a counted pulse takes the leading digit from 9 to 0 upward, `khz_carry` goes high for one cycle, in the next cycle. When it takes that digit from 0 to 9 downward, `khz_borrow` does the same. The two pulses are never high together.
- R12: Every 4-bit digit of `disp_bcd` (bits 4k+3:4k, digit 0 = tens of Hz) is always a value from 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_usb | input | 1 | Fixed preset line: upper-sideband pattern |
| sel_lsb | input | 1 | Fixed preset line: lower-sideband pattern |
| sel_cent | input | 1 | Fixed preset line: channel-centre leading one |
| sel_nm2 | input | 1 | Fixed preset line: minus-two scheme leading digit |
| ofs_count_en | input | 1 | 1 = measured (carrier) offset, 0 = fixed constant |
| dir_down | input | 1 | 1 = count register counts down (offset register up) |
| src_sel | input | 2 | Count register source select |
| vfo_pulse | input | 1 | VFO count strobe |
| ext_pulse | input | 1 | External input count strobe |
| car_pulse | input | 1 | Carrier oscillator count strobe |
| tick_pulse | input | 1 | 10 kHz cycling tick strobe |
| gate_end | input | 1 | Gate timebase strobe closing a gate |
| disp_bcd | output | 4*DIGITS | Latched BCD readout, leading digit on top |
| khz_carry | output | 1 | Upward wrap of the leading digit |
| khz_borrow | output | 1 | Downward wrap of the leading digit |

## Verification
The gate-end reload can fall in the same cycle as a counted VFO pulse or a carrier pulse. These must land in the gate that is closing, not in the one that is opening. The bench ends gates with a strobe that also carries a source pulse, once in a fixed mode and once in the measured-offset mode. It then judges the latched value, or the next gate's readout, against the pulse totals with the coincident pulse included. A second overlap comes from a leading-digit wrap and a direction change in consecutive cycles. This is checked by the carry and borrow pulses appearing exactly one cycle after each wrap.

// File: rtl/offset_preset_counter.sv
`timescale 1ns/1ps
module offset_preset_counter #(
  parameter int DIGITS      = 5,
  parameter int TUBE_CYCLES = 2000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sel_usb,
  input  logic                sel_lsb,
  input  logic                sel_cent,
  input  logic                sel_nm2,
  input  logic                ofs_count_en,
  input  logic                dir_down,
  input  logic [1:0]          src_sel,
  input  logic                vfo_pulse,
  input  logic                ext_pulse,
  input  logic                car_pulse,
  input  logic                tick_pulse,
  input  logic                gate_end,
  output logic [4*DIGITS-1:0] disp_bcd,
  output logic                khz_carry,
  output logic                khz_borrow
);
  localparam int W  = 4 * DIGITS;
  localparam int TW = $clog2(TUBE_CYCLES + 1);

  function automatic logic [W:0] bcd_step(input logic [W-1:0] v, input logic en, input logic up);
    logic [W-1:0] r;
    logic         c;
    logic [3:0]   d;
    r = v;
    c = en;
    for (int i = 0; i < DIGITS; i++) begin
      d = v[4*i +: 4];
      if (c) begin
        if (up) begin
          if (d >= 4'd9) d = 4'd0;
          else begin d = d + 4'd1; c = 1'b0; end
        end else begin
          if (d == 4'd0) d = 4'd9;
          else begin d = d - 4'd1; c = 1'b0; end
        end
      end
      r[4*i +: 4] = d;
    end
    return {c, r};
  endfunction

  logic [W-1:0]  cnt_q, ofs_q, disp_q;
  logic [TW-1:0] tube_cnt;
  logic          tube_on, tube_last;

  assign tube_on   = tube_cnt < TW'(TUBE_CYCLES);
  assign tube_last = tube_cnt == TW'(TUBE_CYCLES - 1);

  logic [15:0]  fixed16;
  logic [W-1:0] fixed_ofs;
  assign fixed16   = {sel_nm2, 2'b00, sel_cent | sel_lsb,
                      sel_usb, 2'b00, sel_usb,
                      sel_usb, 2'b00, sel_lsb,
                      sel_lsb, 1'b0, sel_usb, 1'b0};
  assign fixed_ofs = W'(fixed16) << (W - 16);

  logic cnt_src, cnt_up;
  always_comb begin
    case (src_sel)
      2'd0:    cnt_src = vfo_pulse;
      2'd1:    cnt_src = ext_pulse;
      2'd2:    cnt_src = car_pulse;
      default: cnt_src = tick_pulse;
    endcase
    if (tube_on) cnt_src = tick_pulse;
  end
  assign cnt_up = tube_on | ~dir_down;

  logic [W:0]   cnt_nx, ofs_nx;
  logic [W-1:0] preset;
  logic         reload, latch;
  assign cnt_nx = bcd_step(cnt_q, cnt_src, cnt_up);
  assign ofs_nx = bcd_step(ofs_q, car_pulse, dir_down);
  assign preset = ofs_count_en ? ofs_nx[W-1:0] : fixed_ofs;
  assign latch  = gate_end & ~tube_on;
  assign reload = latch | tube_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      ofs_q      <= '0;
      disp_q     <= '0;
      tube_cnt   <= '0;
      khz_carry  <= 1'b0;
      khz_borrow <= 1'b0;
    end else begin
      if (tube_on) tube_cnt <= tube_cnt + TW'(1);
      khz_carry  <= cnt_nx[W] & cnt_up;
      khz_borrow <= cnt_nx[W] & ~cnt_up;
      if (latch) disp_q <= cnt_nx[W-1:0];
      if (reload) begin
        cnt_q <= preset;
        ofs_q <= ofs_count_en ? '0 : fixed_ofs;
      end else begin
        cnt_q <= cnt_nx[W-1:0];
        ofs_q <= ofs_count_en ? ofs_nx[W-1:0] : fixed_ofs;
      end
    end
  end

  assign disp_bcd = tube_on ? cnt_q : disp_q;
endmodule

// File: rtl/offset_preset_counter_chk.sv
`timescale 1ns/1ps
module offset_preset_counter_chk #(
  parameter int DIGITS = 5
) (
  input logic                clk,
  input logic                rst,
  input logic                gate_end,
  input logic                tube_on,
  input logic [4*DIGITS-1:0] disp_bcd,
  input logic                khz_carry,
  input logic                khz_borrow,
  input logic                vfo_pulse,
  input logic                ext_pulse,
  input logic                car_pulse,
  input logic                tick_pulse
);
  assert_tube_once_R2: assert property (@(posedge clk) disable iff (rst)
    !tube_on |=> !tube_on);

  assert_disp_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!tube_on && !$past(tube_on) && !$past(gate_end)) |-> $stable(disp_bcd));

  assert_wrap_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    !(khz_carry && khz_borrow));

  assert_wrap_cause_R11: assert property (@(posedge clk) disable iff (rst)
    (khz_carry || khz_borrow) |-> $past(vfo_pulse | ext_pulse | car_pulse | tick_pulse));

  for (genvar k = 0; k < DIGITS; k++) begin : g_dig
    assert_bcd_digit_R12: assert property (@(posedge clk) disable iff (rst)
      disp_bcd[4*k +: 4] <= 4'd9);
  end
endmodule

bind offset_preset_counter offset_preset_counter_chk #(.DIGITS(DIGITS)) chk_i (
  .clk(clk), .rst(rst), .gate_end(gate_end), .tube_on(tube_on),
  .disp_bcd(disp_bcd), .khz_carry(khz_carry), .khz_borrow(khz_borrow),
  .vfo_pulse(vfo_pulse), .ext_pulse(ext_pulse), .car_pulse(car_pulse),
  .tick_pulse(tick_pulse)
);

// File: tb/offset_preset_counter_tb_top.sv
`timescale 1ns/1ps
module offset_preset_counter_tb_top;
  localparam int DIGITS = 5;
  localparam int TUBE   = 100;
  localparam int W      = 4 * DIGITS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_usb = 0, sel_lsb = 0, sel_cent = 0, sel_nm2 = 0, ofs_count_en = 0, dir_down = 0;
  logic [1:0] src_sel = 2'd0;
  logic vfo_pulse = 0, ext_pulse = 0, car_pulse = 0, tick_pulse = 0, gate_end = 0;
  logic [W-1:0] disp_bcd;
  logic khz_carry, khz_borrow;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  offset_preset_counter #(.DIGITS(DIGITS), .TUBE_CYCLES(TUBE)) dut_i (
    .clk(clk), .rst(rst), .sel_usb(sel_usb), .sel_lsb(sel_lsb), .sel_cent(sel_cent),
    .sel_nm2(sel_nm2), .ofs_count_en(ofs_count_en), .dir_down(dir_down), .src_sel(src_sel),
    .vfo_pulse(vfo_pulse), .ext_pulse(ext_pulse), .car_pulse(car_pulse),
    .tick_pulse(tick_pulse), .gate_end(gate_end), .disp_bcd(disp_bcd),
    .khz_carry(khz_carry), .khz_borrow(khz_borrow));

  function automatic logic [W-1:0] to_bcd(int v);
    logic [W-1:0] r;
    int m = ((v % 100000) + 100000) % 100000;
    for (int i = 0; i < DIGITS; i++) begin
      r[4*i +: 4] = 4'(m % 10);
      m = m / 10;
    end
    return r;
  endfunction

  task automatic check_val(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_bit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic check_digits_r12();
    logic ok = 1'b1;
    for (int k = 0; k < DIGITS; k++) if (disp_bcd[4*k +: 4] > 4'd9) ok = 1'b0;
    check_bit("R12 digit range", ok, 1'b1);
  endtask

  task automatic step(logic v, logic e, logic c, logic t, logic g);
    vfo_pulse = v; ext_pulse = e; car_pulse = c; tick_pulse = t; gate_end = g;
    @(negedge clk);
    vfo_pulse = 0; ext_pulse = 0; car_pulse = 0; tick_pulse = 0; gate_end = 0;
  endtask

  task automatic pulses(int nv, int ne, int nc, int nt);
    int n = nv;
    if (ne > n) n = ne;
    if (nc > n) n = nc;
    if (nt > n) n = nt;
    for (int i = 0; i < n; i++) step(i < nv, i < ne, i < nc, i < nt, 1'b0);
  endtask

  task automatic end_gate();
    step(0, 0, 0, 0, 1);
  endtask

  task automatic set_mode(logic u, logic l, logic c, logic n2, logic oe, logic dn, logic [1:0] s);
    sel_usb = u; sel_lsb = l; sel_cent = c; sel_nm2 = n2;
    ofs_count_en = oe; dir_down = dn; src_sel = s;
  endtask

  task automatic test_reset_r1();
    repeat (3) @(negedge clk);
    check_val("R1 disp in reset", disp_bcd, '0);
    check_bit("R1 carry in reset", khz_carry, 1'b0);
    check_bit("R1 borrow in reset", khz_borrow, 1'b0);
    set_mode(0, 0, 0, 0, 0, 0, 2'd0);
    rst = 1'b0;
    @(negedge clk);
    check_val("R1 disp after reset", disp_bcd, '0);
  endtask

  task automatic test_tube_r2();
    pulses(5, 0, 0, 7);
    check_val("R2 transparent tick count", disp_bcd, to_bcd(7));
    end_gate();
    check_val("R2 gate ignored in cycling", disp_bcd, to_bcd(7));
    repeat (TUBE) step(0, 0, 0, 0, 0);
    check_val("R2 latched view after cycling", disp_bcd, '0);
    pulses(0, 0, 0, 9);
    check_val("R2 ticks unselected after cycling", disp_bcd, '0);
  endtask

  task automatic test_fixed_r3(logic u, logic l, logic c, logic n2, logic dn, int ofs, int n, string tag);
    set_mode(u, l, c, n2, 0, dn, 2'd0);
    end_gate();
    pulses(n, 0, 0, 0);
    end_gate();
    check_val(tag, disp_bcd, to_bcd(dn ? ofs - n : ofs + n));
    check_digits_r12();
  endtask

  task automatic test_sources_r6();
    set_mode(0, 0, 0, 0, 0, 0, 2'd1);
    end_gate();
    pulses(5, 13, 4, 2);
    end_gate();
    check_val("R6 external source", disp_bcd, to_bcd(13));
    set_mode(0, 0, 0, 0, 0, 0, 2'd2);
    end_gate();
    pulses(3, 0, 7, 1);
    end_gate();
    check_val("R6 carrier source", disp_bcd, to_bcd(7));
    set_mode(0, 0, 0, 0, 0, 0, 2'd3);
    end_gate();
    pulses(6, 2, 0, 4);
    end_gate();
    check_val("R6 tick source", disp_bcd, to_bcd(4));
  endtask

  task automatic test_fixed_ignores_carrier_r8();
    set_mode(0, 0, 1, 0, 0, 1, 2'd0);
    end_gate();
    pulses(10, 0, 30, 0);
    end_gate();
    check_val("R8 carrier ignored gate 1", disp_bcd, to_bcd(10000 - 10));
    pulses(4, 0, 20, 0);
    end_gate();
    check_val("R8 carrier ignored gate 2", disp_bcd, to_bcd(10000 - 4));
  endtask

  task automatic test_variable_r7(logic dn, int c, int v, string tag);
    set_mode(0, 0, 0, 0, 1, dn, 2'd0);
    end_gate();
    end_gate();
    pulses(3, 0, c, 0);
    end_gate();
    pulses(v, 0, 17, 0);
    end_gate();
    check_val(tag, disp_bcd, to_bcd(dn ? c - v : v - c));
    end_gate();
    check_val({tag, " next gate"}, disp_bcd, to_bcd(dn ? 17 : -17));
  endtask

  task automatic test_hold_r9();
    set_mode(0, 0, 0, 0, 0, 0, 2'd0);
    end_gate();
    pulses(21, 0, 0, 0);
    end_gate();
    check_val("R9 latched value", disp_bcd, to_bcd(21));
    pulses(40, 3, 3, 3);
    check_val("R9 held between gate ends", disp_bcd, to_bcd(21));
  endtask

  task automatic test_coincide_r10();
    set_mode(0, 0, 0, 0, 0, 0, 2'd0);
    end_gate();
    pulses(5, 0, 0, 0);
    step(1, 0, 0, 0, 1);
    check_val("R10 count pulse at gate end", disp_bcd, to_bcd(6));
    set_mode(0, 0, 0, 0, 1, 1, 2'd0);
    end_gate();
    end_gate();
    pulses(0, 0, 10, 0);
    step(0, 0, 1, 0, 1);
    end_gate();
    check_val("R10 carrier pulse at gate end", disp_bcd, to_bcd(11));
  endtask

  task automatic test_wrap_r11();
    set_mode(0, 0, 0, 0, 0, 1, 2'd0);
    end_gate();
    step(1, 0, 0, 0, 0);
    check_bit("R11 borrow on 0 to 9", khz_borrow, 1'b1);
    check_bit("R11 no carry with borrow", khz_carry, 1'b0);
    dir_down = 1'b0;
    step(1, 0, 0, 0, 0);
    check_bit("R11 carry on 9 to 0", khz_carry, 1'b1);
    check_bit("R11 no borrow with carry", khz_borrow, 1'b0);
    step(0, 0, 0, 0, 0);
    check_bit("R11 carry one cycle", khz_carry, 1'b0);
    step(1, 0, 0, 0, 0);
    check_bit("R11 no carry without wrap", khz_carry, 1'b0);
    dir_down = 1'b1;
    step(1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    end_gate();
    check_val("R11 readout after borrow", disp_bcd, to_bcd(99999));
  endtask

  initial begin
    test_reset_r1();
    test_tube_r2();
    test_fixed_r3(0, 0, 1, 0, 1, 10000, 37, "R3 R4 centre minus3 down");
    test_fixed_r3(0, 0, 1, 1, 0, 90000, 37, "R3 R5 centre minus2 up");
    test_fixed_r3(1, 0, 0, 0, 1,  9820, 37, "R3 R4 usb minus3 down");
    test_fixed_r3(1, 0, 0, 1, 0, 89820, 37, "R3 R5 usb minus2 up");
    test_fixed_r3(0, 1, 0, 0, 1, 10180, 37, "R3 R4 lsb minus3 down");
    test_fixed_r3(0, 1, 0, 1, 0, 90180, 37, "R3 R5 lsb minus2 up");
    test_fixed_r3(0, 0, 0, 0, 1,     0, 12, "R3 R4 no offset down");
    test_fixed_r3(0, 0, 0, 0, 0,     0, 12, "R3 R5 no offset up");
    test_sources_r6();
    test_fixed_ignores_carrier_r8();
    test_variable_r7(1'b1, 300, 120, "R7 measured offset down");
    test_variable_r7(1'b0, 40, 100, "R7 measured offset up");
    test_hold_r9();
    test_coincide_r10();
    test_wrap_r11();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule